// File: doc/BRIEF.md
# LPC I/O Cycle Target

This block is the peripheral end of a Low Pin Count bus. It samples the frame strobe and the four-bit multiplexed data lines on every rising bus clock edge. It recognises the start of a cycle and the cycle-type nibble, and it collects a 16-bit I/O address. It answers only I/O reads and I/O writes whose address falls inside a window set by parameters. Behind the bus side is a simple register port. The block raises a request there with the address and any write data, and holds it until the register side reports ready.

While the register side is busy, the block holds the bus with wait codes. It then signals ready or error. For a read it returns the byte, and it finishes with its own turnaround. Cycle types it does not serve, and addresses outside the window, leave the bus undriven and the register port untouched.

The controller has nine states:
- IDLE waits for a start.
- CTYPE takes the type nibble. It goes to ADDR for an I/O read or write, and to SKIP for anything else.
- ADDR runs for four nibbles. It goes to SKIP on a window miss, to WDATA for a write, and to HTAR for a read.
- WDATA takes two nibbles and goes to HTAR.
- HTAR is the two-cycle host-to-target turnaround and goes to SYNC.
- SYNC repeats wait codes until the access is served. It then goes to RDATA for a read or PTAR for a write.
- RDATA drives two nibbles and goes to PTAR.
- PTAR is the two-cycle target-to-host turnaround and returns to IDLE.
- SKIP stays until the next frame strobe.

From any state, a sampled low frame strobe moves to CTYPE if the data lines hold the start code, and to IDLE otherwise.

Top module: `lpc_io_target`

## Requirements
- R1: After reset the bus output enable and the register request are both low.
- R2: The nibble after a start (frame low with data 0000) selects the cycle. 0000 is an I/O read and 0010 is an I/O write. Any other type leaves the bus undriven until the next frame strobe.
- R3: The address is 16 bits, taken most significant nibble first over four cycles. An address outside the window (default 0x0300 to 0x030F) causes no bus drive and no register access.
- R4: For a write, the two nibbles after the address form the data byte, least significant nibble first. The register port shows it together with the full address and the write flag set.
- R5: For the two cycles after the last host nibble the block does not drive the bus. It drives a SYNC code in the third cycle.
- R6: While the register side is not ready the block sends wait codes. The first SHORT_WAITS of them (default 2) are 0101 and the rest are 0110. It then sends 0000 for ready. A register latency of L cycles gives max(0, L-1) wait codes.
- R7: A register access completed with error gives SYNC 1010 instead of 0000. For a read, the returned byte is then 0xFF.
- R8: For a read, the byte follows the final SYNC, least significant nibble first.
- R9: After SYNC (write) or data (read), the block drives 1111 for one cycle and then releases the bus. It is ready for a new start in the following cycle.
- R10: A low frame strobe in any state abandons the cycle. The bus is released and the register request is dropped by the next cycle.
- R11: The register request stays high, with its address, write flag and data stable, until ready is sampled. It falls in the cycle after acceptance, so each bus cycle makes exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Frame strobe, active low |
| lad_in | input | 4 | Sampled state of the multiplexed bus lines |
| lad_out | output | 4 | Value driven on the bus lines when enabled |
| lad_oe | output | 1 | Bus drive enable |
| reg_req | output | 1 | Register access request |
| reg_wr | output | 1 | Request is a write |
| reg_addr | output | 16 | Full I/O address of the request |
| reg_wdata | output | 8 | Write byte |
| reg_ready | input | 1 | Register side completes the request |
| reg_rdata | input | 8 | Read byte, valid with ready |
| reg_err | input | 1 | Access failed, valid with ready |

## Verification
The hardest case to reach from the ports is a frame strobe that arrives while the block is part-way through a run of wait codes. At that moment the register request is live and the block owns the bus. The bench holds the register model's latency far above the number of wait cycles it lets pass. It then pulls the frame strobe low in the middle of the wait run and checks, in the next cycle, that the bus is released and the request has gone. It then checks that no access was recorded and that the next read works normally. Wait-code sequences past the short-wait limit are reached by setting the register latency per transfer.

// File: rtl/lpc_io_pkg.sv
package lpc_io_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTYPE,
        ST_ADDR,
        ST_WDATA,
        ST_HTAR,
        ST_SYNC,
        ST_RDATA,
        ST_PTAR,
        ST_SKIP
    } lpc_state_e;

    localparam logic [3:0] NIB_START  = 4'h0;
    localparam logic [3:0] CT_IO_RD   = 4'h0;
    localparam logic [3:0] CT_IO_WR   = 4'h2;
    localparam logic [3:0] SYNC_READY = 4'h0;
    localparam logic [3:0] SYNC_SHORT = 4'h5;
    localparam logic [3:0] SYNC_LONG  = 4'h6;
    localparam logic [3:0] SYNC_ERR   = 4'hA;
    localparam logic [3:0] NIB_ONES   = 4'hF;

endpackage

// File: rtl/lpc_nib_shift.sv
// Collects NIBS nibbles into a word, either most or least significant first.
module lpc_nib_shift #(
    parameter int NIBS      = 4,
    parameter bit LSN_FIRST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [3:0]        nib,
    output logic [NIBS*4-1:0] q,
    output logic [NIBS*4-1:0] q_nxt
);
    localparam int W = NIBS * 4;

    logic [W-1:0] shifted;

    generate
        if (LSN_FIRST) begin : g_lsn
            assign shifted = {nib, q[W-1:4]};
        end else begin : g_msn
            assign shifted = {q[W-5:0], nib};
        end
    endgenerate

    assign q_nxt = en ? shifted : q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end
endmodule

// File: rtl/lpc_win_match.sv
// Address window compare: aligned block of 2**SPAN_LOG2 bytes at BASE.
module lpc_win_match #(
    parameter logic [15:0] BASE      = 16'h0300,
    parameter int          SPAN_LOG2 = 4
) (
    input  logic [15:0] addr,
    output logic        hit
);
    logic [15:0] diff;
    assign diff = (addr ^ BASE) >> SPAN_LOG2;
    assign hit  = (diff == 16'h0000);
endmodule

// File: rtl/lpc_wait_ctr.sv
// Chooses the wait code: short for the first SHORT_WAITS waits, long after.
module lpc_wait_ctr
    import lpc_io_pkg::*;
#(
    parameter int SHORT_WAITS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       step,
    output logic [3:0] code
);
    localparam int CW = $clog2(SHORT_WAITS + 2);
    localparam logic [CW-1:0] LIMIT = CW'(SHORT_WAITS);

    logic [CW-1:0] n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    n <= '0;
        else if (clr)                  n <= '0;
        else if (step && n != LIMIT)   n <= n + 1'b1;
    end

    assign code = (n < LIMIT) ? SYNC_SHORT : SYNC_LONG;
endmodule

// File: rtl/lpc_io_target.sv
module lpc_io_target
    import lpc_io_pkg::*;
#(
    parameter logic [15:0] WIN_BASE      = 16'h0300,
    parameter int          WIN_SPAN_LOG2 = 4,
    parameter int          SHORT_WAITS   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_n,
    input  logic [3:0]  lad_in,
    output logic [3:0]  lad_out,
    output logic        lad_oe,
    output logic        reg_req,
    output logic        reg_wr,
    output logic [15:0] reg_addr,
    output logic [7:0]  reg_wdata,
    input  logic        reg_ready,
    input  logic [7:0]  reg_rdata,
    input  logic        reg_err
);
    localparam int ADDR_NIBS = 4;
    localparam int DATA_NIBS = 2;
    localparam logic [1:0] ADDR_LAST = 2'(ADDR_NIBS - 1);
    localparam logic [1:0] PAIR_LAST = 2'(DATA_NIBS - 1);

    lpc_state_e state, state_nx;
    logic [1:0] cnt, cnt_nx;
    logic       is_wr_q;
    logic       served_q;
    logic       err_q;
    logic [7:0] rdata_q;

    logic [15:0] addr_q, addr_nx;
    logic [7:0]  wdata_q, wdata_nx;
    logic        win_hit;
    logic [3:0]  wait_code;

    // field collectors
    lpc_nib_shift #(.NIBS(ADDR_NIBS), .LSN_FIRST(1'b0)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state == ST_ADDR),
        .nib   (lad_in),
        .q     (addr_q),
        .q_nxt (addr_nx)
    );

    lpc_nib_shift #(.NIBS(DATA_NIBS), .LSN_FIRST(1'b1)) u_wdata (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state == ST_WDATA),
        .nib   (lad_in),
        .q     (wdata_q),
        .q_nxt (wdata_nx)
    );

    lpc_win_match #(.BASE(WIN_BASE), .SPAN_LOG2(WIN_SPAN_LOG2)) u_win (
        .addr (addr_nx),
        .hit  (win_hit)
    );

    lpc_wait_ctr #(.SHORT_WAITS(SHORT_WAITS)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != ST_SYNC),
        .step  (state == ST_SYNC && !served_q),
        .code  (wait_code)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (!frame_n) begin
            state_nx = (lad_in == NIB_START) ? ST_CTYPE : ST_IDLE;
            cnt_nx   = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_nx = ST_IDLE;
                end
                ST_CTYPE: begin
                    cnt_nx = '0;
                    if (lad_in == CT_IO_RD || lad_in == CT_IO_WR) state_nx = ST_ADDR;
                    else                                          state_nx = ST_SKIP;
                end
                ST_ADDR: begin
                    if (cnt == ADDR_LAST) begin
                        cnt_nx = '0;
                        if (!win_hit)     state_nx = ST_SKIP;
                        else if (is_wr_q) state_nx = ST_WDATA;
                        else              state_nx = ST_HTAR;
                    end else begin
                        cnt_nx = cnt + 2'd1;
                    end
                end
                ST_WDATA: begin
                    if (cnt == PAIR_LAST) begin
                        cnt_nx   = '0;
                        state_nx = ST_HTAR;
                    end else begin
                        cnt_nx = cnt + 2'd1;
                    end
                end
                ST_HTAR: begin
                    if (cnt == 2'd1) begin
                        cnt_nx   = '0;
                        state_nx = ST_SYNC;
                    end else begin
                        cnt_nx = cnt + 2'd1;
                    end
                end
                ST_SYNC: begin
                    cnt_nx = '0;
                    if (served_q) state_nx = is_wr_q ? ST_PTAR : ST_RDATA;
                end
                ST_RDATA: begin
                    if (cnt == PAIR_LAST) begin
                        cnt_nx   = '0;
                        state_nx = ST_PTAR;
                    end else begin
                        cnt_nx = cnt + 2'd1;
                    end
                end
                ST_PTAR: begin
                    if (cnt == 2'd1) begin
                        cnt_nx   = '0;
                        state_nx = ST_IDLE;
                    end else begin
                        cnt_nx = cnt + 2'd1;
                    end
                end
                ST_SKIP: begin
                    state_nx = ST_SKIP;
                end
                default: begin
                    state_nx = ST_IDLE;
                    cnt_nx   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // cycle attributes and register-side completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_wr_q  <= 1'b0;
            served_q <= 1'b0;
            err_q    <= 1'b0;
            rdata_q  <= '0;
        end else begin
            if (state == ST_CTYPE && frame_n)
                is_wr_q <= (lad_in == CT_IO_WR);
            if (reg_req && reg_ready) begin
                served_q <= 1'b1;
                err_q    <= reg_err;
                rdata_q  <= reg_err ? 8'hFF : reg_rdata;
            end else if (state != ST_HTAR && state_nx == ST_HTAR) begin
                served_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        lad_oe  = 1'b0;
        lad_out = NIB_ONES;
        unique case (state)
            ST_SYNC: begin
                lad_oe  = 1'b1;
                lad_out = served_q ? (err_q ? SYNC_ERR : SYNC_READY) : wait_code;
            end
            ST_RDATA: begin
                lad_oe  = 1'b1;
                lad_out = (cnt == 2'd0) ? rdata_q[3:0] : rdata_q[7:4];
            end
            ST_PTAR: begin
                lad_oe  = (cnt == 2'd0);
                lad_out = NIB_ONES;
            end
            ST_IDLE, ST_CTYPE, ST_ADDR, ST_WDATA, ST_HTAR, ST_SKIP: begin
                lad_oe  = 1'b0;
                lad_out = NIB_ONES;
            end
            default: begin
                lad_oe  = 1'b0;
                lad_out = NIB_ONES;
            end
        endcase
    end

    assign reg_req   = (state == ST_HTAR || state == ST_SYNC) && !served_q;
    assign reg_wr    = is_wr_q;
    assign reg_addr  = addr_q;
    assign reg_wdata = wdata_q;

endmodule

// File: rtl/lpc_io_target_chk.sv
module lpc_io_target_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_n,
    input logic [3:0]  lad_out,
    input logic        lad_oe,
    input logic        reg_req,
    input logic        reg_wr,
    input logic [15:0] reg_addr,
    input logic [7:0]  reg_wdata,
    input logic        reg_ready
);
    // R10: frame strobe releases the bus by the next cycle
    p_release_on_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> !lad_oe);

    // R11: request held stable until accepted
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ready && frame_n) |=>
            (reg_req && $stable(reg_addr) && $stable(reg_wr) && $stable(reg_wdata)));

    // R11: one acceptance per request
    p_single_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_ready) |=> !reg_req);

    // R9: a normal release is preceded by a cycle of all ones
    p_tar_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lad_oe) && $past(frame_n)) |-> ($past(lad_out) == 4'hF));

    // R5: the bus is never taken without two undriven cycles before
    p_gap_before_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lad_oe) |-> !$past(lad_oe, 2));
endmodule

bind lpc_io_target lpc_io_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .lad_out   (lad_out),
    .lad_oe    (lad_oe),
    .reg_req   (reg_req),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_ready (reg_ready)
);

// File: tb/lpc_io_target_test.sv
`timescale 1ns/1ps
module lpc_io_target_test;
    localparam int CLK_PERIOD = 30;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  data;
    } acc_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_n;
    logic        host_oe;
    logic [3:0]  host_val;
    logic [3:0]  lad_in;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic        reg_req, reg_wr;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_ready;
    logic [7:0]  reg_rdata;
    logic        reg_err;

    int compared = 0;
    int mismatched = 0;
    int lat_cfg = 0;
    bit err_cfg = 0;
    logic [7:0] shadow [16];
    logic [7:0] exp_mem [16];
    acc_t exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // bus resolution with pull-ups
    assign lad_in = lad_oe ? lad_out : (host_oe ? host_val : 4'hF);

    lpc_io_target uut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
        .lad_out(lad_out), .lad_oe(lad_oe), .reg_req(reg_req), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ready(reg_ready),
        .reg_rdata(reg_rdata), .reg_err(reg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // register side model with configurable latency
    initial begin
        int mcnt;
        mcnt = 0;
        reg_ready = 1'b0;
        reg_rdata = 8'h00;
        reg_err = 1'b0;
        for (int i = 0; i < 16; i++) shadow[i] = 8'h00;
        forever begin
            @(negedge clk);
            if (reg_ready) begin
                reg_ready = 1'b0;
                reg_err = 1'b0;
            end else if (reg_req) begin
                if (mcnt >= lat_cfg) begin
                    reg_ready = 1'b1;
                    reg_err = err_cfg;
                    if (!reg_wr) reg_rdata = shadow[reg_addr[3:0]];
                    else if (!err_cfg) shadow[reg_addr[3:0]] = reg_wdata;
                    mcnt = 0;
                end else begin
                    mcnt++;
                end
            end else begin
                mcnt = 0;
            end
        end
    end

    // scoreboard monitor on the register port
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n === 1'b1 && reg_req && reg_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R3 unexpected register access", int'(reg_addr), 0);
                end else begin
                    acc_t e;
                    e = exp_q.pop_front();
                    chk(reg_wr == e.wr, "R2 access direction", int'(reg_wr), int'(e.wr));
                    chk(reg_addr == e.addr, "R11 access address", int'(reg_addr), int'(e.addr));
                    if (e.wr)
                        chk(reg_wdata == e.data, "R4 write byte", int'(reg_wdata), int'(e.data));
                end
            end
        end
    end

    task automatic host(input logic f, input logic [3:0] n);
        @(negedge clk);
        frame_n = f;
        host_oe = 1'b1;
        host_val = n;
    endtask

    task automatic release_bus();
        @(negedge clk);
        frame_n = 1'b1;
        host_oe = 1'b0;
    endtask

    task automatic send_head(input logic [3:0] ct, input logic [15:0] a);
        host(1'b0, 4'h0);
        host(1'b1, ct);
        for (int i = 3; i >= 0; i--) host(1'b1, a[i*4 +: 4]);
    endtask

    task automatic io_cycle(input bit wr, input logic [15:0] a, input logic [7:0] wd,
                            input int lat, input bit err);
        int waits;
        bit done;
        logic [3:0] code;
        logic [3:0] lo;
        int exp_waits;
        logic [7:0] exp_rd;
        acc_t e;
        lat_cfg = lat;
        err_cfg = err;
        e.wr = wr; e.addr = a; e.data = wd;
        exp_q.push_back(e);
        exp_waits = (lat > 1) ? lat - 1 : 0;
        exp_rd = err ? 8'hFF : exp_mem[a[3:0]];
        if (wr && !err) exp_mem[a[3:0]] = wd;
        send_head(wr ? 4'h2 : 4'h0, a);
        if (wr) begin
            host(1'b1, wd[3:0]);
            host(1'b1, wd[7:4]);
        end
        host(1'b1, 4'hF);
        #2 chk(!lad_oe, "R5 turnaround cycle 1 undriven", int'(lad_oe), 0);
        release_bus();
        #2 chk(!lad_oe, "R5 turnaround cycle 2 undriven", int'(lad_oe), 0);
        waits = 0;
        done = 0;
        code = 4'hF;
        for (int k = 0; k < 64 && !done; k++) begin
            @(negedge clk);
            #2;
            if (!lad_oe) begin
                chk(0, "R5 SYNC expected on bus", int'(lad_oe), 1);
                done = 1;
            end else if (lad_in == 4'h5 || lad_in == 4'h6) begin
                chk(lad_in == ((waits < 2) ? 4'h5 : 4'h6), "R6 wait code kind",
                    int'(lad_in), (waits < 2) ? 5 : 6);
                waits++;
            end else begin
                code = lad_in;
                done = 1;
            end
        end
        chk(waits == exp_waits, "R6 wait count", waits, exp_waits);
        chk(code == (err ? 4'hA : 4'h0), err ? "R7 error SYNC" : "R6 ready SYNC",
            int'(code), err ? 10 : 0);
        if (!wr) begin
            @(negedge clk); #2 lo = lad_in;
            @(negedge clk); #2;
            chk({lad_in, lo} == exp_rd, err ? "R7 read byte on error" : "R8 read byte",
                int'({lad_in, lo}), int'(exp_rd));
        end
        @(negedge clk); #2;
        chk(lad_oe && lad_in == 4'hF, "R9 drives ones", int'({lad_oe, lad_in}), 'h1F);
        @(negedge clk); #2;
        chk(!lad_oe, "R9 releases bus", int'(lad_oe), 0);
    endtask

    task automatic expect_silent(input string req, input int cycles);
        bit seen;
        seen = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk); #2;
            if (lad_oe || reg_req) seen = 1;
        end
        chk(!seen, req, int'(seen), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        frame_n = 1'b1;
        host_oe = 1'b0;
        host_val = 4'hF;
        for (int i = 0; i < 16; i++) exp_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        #2 chk(!lad_oe && !reg_req, "R1 reset outputs", int'({lad_oe, reg_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #2 chk(!lad_oe && !reg_req, "R1 idle after reset", int'({lad_oe, reg_req}), 0);

        io_cycle(1, 16'h0305, 8'hA5, 0, 0);   // R4 write, no wait
        io_cycle(0, 16'h0305, 8'h00, 1, 0);   // R8 read back
        io_cycle(1, 16'h030F, 8'h3C, 3, 0);   // R6 two short waits
        io_cycle(0, 16'h030F, 8'h00, 5, 0);   // R6 short then long
        io_cycle(0, 16'h0300, 8'h00, 0, 0);   // R8 untouched location

        // R3: write outside the window is ignored
        send_head(4'h2, 16'h0315);
        host(1'b1, 4'h7); host(1'b1, 4'hE);
        host(1'b1, 4'hF);
        release_bus();
        expect_silent("R3 miss leaves bus and port idle", 8);
        io_cycle(0, 16'h0305, 8'h00, 2, 0);   // R3 0x0305 still holds A5

        // R2: non-I/O cycle type ignored
        send_head(4'h4, 16'h0305);
        host(1'b1, 4'hF); host(1'b1, 4'hF); host(1'b1, 4'hF); host(1'b1, 4'hF);
        host(1'b1, 4'hF);
        release_bus();
        expect_silent("R2 other cycle type ignored", 10);

        io_cycle(0, 16'h0301, 8'h00, 2, 1);   // R7 error read

        // R10: abort in the middle of a wait run
        lat_cfg = 20;
        err_cfg = 0;
        send_head(4'h0, 16'h0301);
        host(1'b1, 4'hF);
        release_bus();
        repeat (4) @(negedge clk);
        #2 chk(lad_oe && lad_in == 4'h6, "R10 waits before abort", int'(lad_in), 6);
        host(1'b0, 4'hF);
        release_bus();
        #2 chk(!lad_oe && !reg_req, "R10 abort releases", int'({lad_oe, reg_req}), 0);
        expect_silent("R10 stays quiet after abort", 4);

        io_cycle(0, 16'h030F, 8'h00, 0, 0);   // R9 normal service after abort

        for (int i = 0; i < 6; i++)
            io_cycle(1, 16'h0300 + 16'(i * 2), 8'(8'h11 * (i + 3)), i, 0);
        for (int i = 0; i < 6; i++)
            io_cycle(0, 16'h0300 + 16'(i * 2), 8'h00, 5 - i, 0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R11 every expected access seen", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        compared++;
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule